// File: doc/BRIEF.md
# Effective Address Unit

This block turns one operand specifier into a byte address. The caller presents a 3-bit mode code together with an instruction constant, a base register value, an index register value, a 2-bit scale code and a 2-bit access-size code, and pulses `start`. The unit replies with a one-cycle `done` pulse. At that point `ea` holds the computed address, and it keeps that value until the next `done`.

Most modes take one cycle. The memory-indirect mode is the exception. It reads a pointer from memory through a request/response port and waits for the response. The pointer it receives becomes the address.

The two auto-adjusting modes produce a new base value. This value goes out on a writeback port, qualified by a one-cycle enable that arrives together with `done`, so the register file can update the base register. All arithmetic wraps modulo 2^AW, and overflow is never signalled.

Top module: `eff_addr_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `done`, `err`, `busy`, `rd_req` and `wb_en` are 0 and `ea` is 0.
- R2: Mode 0 (absolute): `ea` equals `imm`. For every mode except 4, `done` is high in the cycle that follows the cycle in which `start` was sampled high while idle.
- R3: Mode 1 (register indirect): `ea` equals `base_val`.
- R4: Mode 2 (displaced): `ea` equals `base_val + imm`.
- R5: Mode 3 (indexed): `ea` equals `base_val + index_val * F`, where `scale_sel` 0/1/2/3 gives F = 1/2/4/8.
- R6: Mode 4 (memory indirect): in the cycle after `start`, `rd_req` rises with `rd_addr = base_val` and `busy` high. Both stay constant until `rd_valid` is sampled high. In the following cycle `done` is high, `ea` equals the `rd_data` sampled with `rd_valid`, and `rd_req` and `busy` are low.
- R7: `start` sampled while `busy` is high has no effect. `rd_valid` sampled while no request is outstanding has no effect.
- R8: Mode 5 (auto-increment): `ea` equals `base_val`. `wb_en` pulses together with `done`, with `wb_val = base_val + S`. `size_sel` 0/1/2/3 gives S = 1/2/4/4.
- R9: Mode 6 (auto-decrement): `ea` and `wb_val` both equal `base_val - S`, and `wb_en` pulses together with `done`.
- R10: Mode 7 (reserved): `done` and `err` pulse together, `ea` becomes 0, and neither `wb_en` nor `rd_req` is raised. `err` is 0 whenever `done` belongs to a valid mode.
- R11: Every sum and difference wraps modulo 2^32 with no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation (ignored while busy) |
| mode | input | 3 | Addressing mode code |
| imm | input | 32 | Instruction constant / displacement |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| scale_sel | input | 2 | Index multiplier code |
| size_sel | input | 2 | Access size code |
| rd_valid | input | 1 | Pointer read response valid |
| rd_data | input | 32 | Pointer read response data |
| busy | output | 1 | Waiting for a pointer read |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Reserved mode code, pulses with done |
| ea | output | 32 | Effective address, held after done |
| rd_req | output | 1 | Pointer read request, held until response |
| rd_addr | output | 32 | Pointer read address |
| wb_en | output | 1 | Base writeback enable, pulses with done |
| wb_val | output | 32 | New base register value |

## Verification
A behavioural model runs alongside the unit and is compared with it on every clock. Directed cases cover each mode with values chosen so that two modes would give different answers: for example, base and immediate differ, and index and scale make every multiplier visible. Near-maximum operands force wraparound in the displaced, indexed and auto-adjust sums. Memory-indirect cases use response latencies of zero to several cycles and inject `start` pulses during the wait, which separates a held request from a restarted one. A long random phase mixes all eight codes, back-to-back starts and stray responses.

// File: rtl/eau_pkg.sv
package eau_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_ABS     = 3'd0,
    MODE_REGIND  = 3'd1,
    MODE_DISP    = 3'd2,
    MODE_INDEX   = 3'd3,
    MODE_MEMIND  = 3'd4,
    MODE_AUTOINC = 3'd5,
    MODE_AUTODEC = 3'd6,
    MODE_RSVD    = 3'd7
  } eau_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } eau_state_e;

  // access size code to byte count: 0->1, 1->2, 2/3->4
  function automatic int unsigned size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/eau_calc.sv
module eau_calc
  import eau_pkg::*;
#(
  parameter int AW  = 32,
  parameter int SCW = 2
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [AW-1:0]     imm_i,
  input  logic [AW-1:0]     base_i,
  input  logic [AW-1:0]     index_i,
  input  logic [SCW-1:0]    scale_i,
  input  logic [1:0]        size_i,
  output logic [AW-1:0]     ea_o,
  output logic [AW-1:0]     wb_o,
  output logic              wb_need_o,
  output logic              ind_o,
  output logic              rsvd_o
);
  localparam int NSCALE = 1 << SCW;

  logic [AW-1:0] shifted [NSCALE];
  logic [AW-1:0] scaled;
  logic [AW-1:0] step;
  logic [AW-1:0] dec_val;

  generate
    for (genvar g = 0; g < NSCALE; g++) begin : g_scale
      assign shifted[g] = index_i << g;
    end
  endgenerate

  assign scaled  = shifted[scale_i];
  assign step    = AW'(size_bytes(size_i));
  assign dec_val = base_i - step;

  always_comb begin
    ea_o      = '0;
    wb_o      = '0;
    wb_need_o = 1'b0;
    ind_o     = 1'b0;
    rsvd_o    = 1'b0;
    case (eau_mode_e'(mode_i))
      MODE_ABS:    ea_o = imm_i;
      MODE_REGIND: ea_o = base_i;
      MODE_DISP:   ea_o = base_i + imm_i;
      MODE_INDEX:  ea_o = base_i + scaled;
      MODE_MEMIND: begin
        ind_o = 1'b1;
        ea_o  = base_i;
      end
      MODE_AUTOINC: begin
        ea_o      = base_i;
        wb_o      = base_i + step;
        wb_need_o = 1'b1;
      end
      MODE_AUTODEC: begin
        ea_o      = dec_val;
        wb_o      = dec_val;
        wb_need_o = 1'b1;
      end
      default: rsvd_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/eau_seq.sv
module eau_seq
  import eau_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          ind_i,
  input  logic          rsvd_i,
  input  logic          wb_need_i,
  input  logic [AW-1:0] ea_calc_i,
  input  logic [AW-1:0] wb_calc_i,
  input  logic [AW-1:0] base_i,
  input  logic          rd_valid_i,
  input  logic [AW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [AW-1:0] ea_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_val_o
);
  eau_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
      ea_o      <= '0;
      rd_req_o  <= 1'b0;
      rd_addr_o <= '0;
      wb_en_o   <= 1'b0;
      wb_val_o  <= '0;
    end else begin
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      wb_en_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            if (ind_i) begin
              rd_req_o  <= 1'b1;
              rd_addr_o <= base_i;
              state     <= ST_WAIT;
            end else begin
              done_o <= 1'b1;
              err_o  <= rsvd_i;
              ea_o   <= ea_calc_i;
              if (wb_need_i) begin
                wb_en_o  <= 1'b1;
                wb_val_o <= wb_calc_i;
              end
            end
          end
        end
        default: begin
          if (rd_valid_i) begin
            rd_req_o <= 1'b0;
            done_o   <= 1'b1;
            ea_o     <= rd_data_i;
            state    <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign busy_o = (state == ST_WAIT);

  AST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && !ind_i) |=> done_o); // R2
  AST_IND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o) && !done_o)); // R6
  AST_IND_FINISH: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && rd_valid_i) |=> (done_o && !rd_req_o && !busy_o)); // R6
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !rd_valid_i) |=> (!done_o && busy_o)); // R7
  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    wb_en_o |-> (done_o && !err_o)); // R8
  AST_RSVD_CLEAN: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (done_o && !wb_en_o && !rd_req_o)); // R10
endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
  import eau_pkg::*;
#(
  parameter int AW  = 32,
  parameter int SCW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [AW-1:0]     imm,
  input  logic [AW-1:0]     base_val,
  input  logic [AW-1:0]     index_val,
  input  logic [SCW-1:0]    scale_sel,
  input  logic [1:0]        size_sel,
  input  logic              rd_valid,
  input  logic [AW-1:0]     rd_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [AW-1:0]     ea,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  output logic              wb_en,
  output logic [AW-1:0]     wb_val
);
  logic [AW-1:0] ea_calc;
  logic [AW-1:0] wb_calc;
  logic          wb_need;
  logic          ind;
  logic          rsvd;

  eau_calc #(.AW(AW), .SCW(SCW)) u_calc (
    .mode_i    (mode),
    .imm_i     (imm),
    .base_i    (base_val),
    .index_i   (index_val),
    .scale_i   (scale_sel),
    .size_i    (size_sel),
    .ea_o      (ea_calc),
    .wb_o      (wb_calc),
    .wb_need_o (wb_need),
    .ind_o     (ind),
    .rsvd_o    (rsvd)
  );

  eau_seq #(.AW(AW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .ind_i      (ind),
    .rsvd_i     (rsvd),
    .wb_need_i  (wb_need),
    .ea_calc_i  (ea_calc),
    .wb_calc_i  (wb_calc),
    .base_i     (base_val),
    .rd_valid_i (rd_valid),
    .rd_data_i  (rd_data),
    .busy_o     (busy),
    .done_o     (done),
    .err_o      (err),
    .ea_o       (ea),
    .rd_req_o   (rd_req),
    .rd_addr_o  (rd_addr),
    .wb_en_o    (wb_en),
    .wb_val_o   (wb_val)
  );
endmodule

// File: tb/tb_eff_addr_unit.sv
module tb_eff_addr_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [31:0] imm = '0, base_val = '0, index_val = '0, rd_data = '0;
  logic [1:0]  scale_sel = '0, size_sel = '0;
  logic        rd_valid = 1'b0;
  logic        busy, done, err, rd_req, wb_en;
  logic [31:0] ea, rd_addr, wb_val;

  always #10 clk = ~clk; // 50 MHz

  eff_addr_unit dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .imm(imm),
    .base_val(base_val), .index_val(index_val), .scale_sel(scale_sel),
    .size_sel(size_sel), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .done(done), .err(err), .ea(ea), .rd_req(rd_req),
    .rd_addr(rd_addr), .wb_en(wb_en), .wb_val(wb_val)
  );

  int vecs = 0;
  int miss = 0;

  // reference model state
  logic        m_busy = 0, m_done = 0, m_err = 0, m_req = 0, m_wb = 0;
  logic [31:0] m_ea = 0, m_raddr = 0, m_wbv = 0;
  string       m_tag = "R1";
  bit          after_rst = 1'b1;

  function automatic bit carry_add(input logic [31:0] a, input logic [31:0] b);
    logic [32:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[32];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_err = 0; m_req = 0; m_wb = 0;
      m_ea = 0; m_tag = "R1"; after_rst = 1'b1;
    end else begin
      logic [31:0] step, mult;
      after_rst = 1'b0;
      m_done = 0; m_err = 0; m_wb = 0;
      step = (size_sel == 0) ? 1 : (size_sel == 1) ? 2 : 4;
      mult = 32'd1 << scale_sel;
      if (m_busy) begin
        if (rd_valid) begin
          m_busy = 0; m_req = 0; m_done = 1; m_ea = rd_data; m_tag = "R6";
        end else m_tag = "R7";
      end else if (start) begin
        m_done = 1;
        case (mode)
          3'd0: begin m_ea = imm; m_tag = "R2"; end
          3'd1: begin m_ea = base_val; m_tag = "R3"; end
          3'd2: begin m_ea = base_val + imm;
                      m_tag = carry_add(base_val, imm) ? "R11" : "R4"; end
          3'd3: begin m_ea = base_val + index_val * mult;
                      m_tag = ((64'(index_val) * mult) + base_val > 64'hFFFF_FFFF) ? "R11" : "R5"; end
          3'd4: begin m_done = 0; m_busy = 1; m_req = 1; m_raddr = base_val; m_tag = "R6"; end
          3'd5: begin m_ea = base_val; m_wb = 1; m_wbv = base_val + step;
                      m_tag = carry_add(base_val, step) ? "R11" : "R8"; end
          3'd6: begin m_ea = base_val - step; m_wb = 1; m_wbv = base_val - step;
                      m_tag = (base_val < step) ? "R11" : "R9"; end
          default: begin m_ea = 0; m_err = 1; m_tag = "R10"; end
        endcase
      end else if (rd_valid) m_tag = "R7";
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    string t;
    t = (rst || after_rst) ? "R1" : m_tag;
    chk(done === m_done, t, "done", 32'(done), 32'(m_done));
    chk(err === m_err, m_err ? "R10" : t, "err", 32'(err), 32'(m_err));
    chk(busy === m_busy, m_busy ? "R6" : t, "busy", 32'(busy), 32'(m_busy));
    chk(ea === m_ea, t, "ea", ea, m_ea);
    chk(rd_req === m_req, m_req ? "R6" : t, "rd_req", 32'(rd_req), 32'(m_req));
    if (m_req) chk(rd_addr === m_raddr, "R6", "rd_addr", rd_addr, m_raddr);
    chk(wb_en === m_wb, t, "wb_en", 32'(wb_en), 32'(m_wb));
    if (m_wb) chk(wb_val === m_wbv, t, "wb_val", wb_val, m_wbv);
  end

  task automatic issue(input logic [2:0] md, input logic [31:0] im, input logic [31:0] b,
                       input logic [31:0] ix, input logic [1:0] sc, input logic [1:0] sz);
    @(negedge clk);
    start = 1; mode = md; imm = im; base_val = b; index_val = ix;
    scale_sel = sc; size_sel = sz;
    @(negedge clk);
    start = 0;
  endtask

  // memory-indirect: wait lat cycles (poking start), then respond with ptr
  task automatic indirect(input logic [31:0] b, input int lat, input logic [31:0] ptr);
    @(negedge clk);
    start = 1; mode = 3'd4; base_val = b;
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      start = 1; mode = 3'(i % 4); base_val = b ^ 32'h55; // R7: ignored while busy
    end
    @(negedge clk);
    start = 0; rd_valid = 1; rd_data = ptr;
    @(negedge clk);
    rd_valid = 0;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      miss++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk); // R1 reset state checked each cycle
    rst = 0;
    @(negedge clk);
    issue(3'd0, 32'hCAFE_0000, 32'h1111, 32'h2, 0, 0);          // R2
    issue(3'd1, 32'hDEAD, 32'h0000_4000, 32'h2, 0, 0);          // R3
    issue(3'd2, 32'h64, 32'h0000_4000, 32'h2, 0, 0);            // R4
    for (int s = 0; s < 4; s++)
      issue(3'd3, 32'h9, 32'h1000, 32'h3, 2'(s), 0);           // R5
    indirect(32'h2000, 0, 32'hABCD_0010);                        // R6
    indirect(32'h3000, 3, 32'h0BAD_F00D);                        // R6 R7
    for (int z = 0; z < 4; z++) issue(3'd5, 0, 32'h100, 0, 0, 2'(z)); // R8
    for (int z = 0; z < 4; z++) issue(3'd6, 0, 32'h100, 0, 0, 2'(z)); // R9
    issue(3'd7, 32'h77, 32'h88, 0, 0, 0);                        // R10
    issue(3'd2, 32'h10, 32'hFFFF_FFF8, 0, 0, 0);                 // R11
    issue(3'd3, 0, 32'hFFFF_FF00, 32'h4000_0000, 3, 0);          // R11
    issue(3'd5, 0, 32'hFFFF_FFFE, 0, 0, 2);                      // R11
    issue(3'd6, 0, 32'h1, 0, 0, 2);                              // R11
    @(negedge clk); rd_valid = 1; rd_data = 32'h1234;            // R7 stray response
    @(negedge clk); rd_valid = 0;
    for (int n = 0; n < 400; n++) begin
      logic [2:0] md;
      md = 3'($urandom % 8);
      if (md == 3'd4) indirect($urandom, int'($urandom % 4), $urandom);
      else issue(md, $urandom, $urandom, $urandom, 2'($urandom), 2'($urandom));
      if ($urandom % 5 == 0) begin
        @(negedge clk); rd_valid = 1; rd_data = $urandom;          // R7
        @(negedge clk); rd_valid = 0;
      end
    end
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule